// File: doc/BRIEF.md
# Per-Lane Link Error Status Bank

This block collects error events from a multi-lane serial receiver and from the transmit alignment logic, and holds them as status that a register read can fetch. Each receive lane has a small saturating counter of CRC errors and a sticky flag for sync header (framing bit) errors. Two global sticky flags record loss of receive lane-to-lane alignment and loss of transmit alignment. A TX alignment loss is caused by a transmit FIFO overflow or underflow. Each event arrives as a single-cycle pulse.

Status is never cleared by reading it. A write to a clear register empties it instead, and each kind of status has its own bit in that register. Reads are combinational: the word selected by `rd_addr` appears on `rd_data` in the same cycle. CRC counters are packed eight lanes to a 32-bit word, with each lane in its own nibble. The sync header flags form one vector in which the bit index equals the lane index. The two alignment flags share one further word.

With the default of 24 lanes, the words are laid out as follows:

| Address | Contents |
|---|---|
| 0 | CRC counters for lanes 0 to 7 |
| 1 | CRC counters for lanes 8 to 15 |
| 2 | CRC counters for lanes 16 to 23 |
| 3 | Sync header flags |
| 4 | Alignment flags |

Top module: `lane_err_status`

## Requirements
- R1: A synchronous active-high `rst` sets every CRC counter and every sticky flag to zero, so that every readable word returns 0.
- R2: In each cycle where `crc_err_evt[i]` is high, the CRC counter of lane i goes up by one. Only lane i is affected.
- R3: A CRC counter that has reached 0xF stays at 0xF on further events and does not wrap.
- R4: A write (`clr_we` high) with `clr_data[6]` = 1 sets all CRC counters to zero. A write with bit 6 at 0 leaves the counters unchanged.
- R5: The sync header flag of lane i sets on `sh_err_evt[i]` and stays set. The flags are read at address 3 (default lanes), with bit i belonging to lane i.
- R6: A write with `clr_data[7]` = 1 clears all sync header flags. Writes that clear other status leave these flags alone.
- R7: The RX loss-of-alignment flag is bit 0 of the alignment word (address 4). It sets on `rx_align_lost_evt`, holds, and is cleared by a write with `clr_data[8]` = 1.
- R8: The TX loss-of-alignment flag is bit 1 of the alignment word. It sets on `tx_align_lost_evt`, holds, and is cleared by a write with `clr_data[9]` = 1.
- R9: If an event and a clear of the same status land in one cycle, the event wins. A flag ends up set, and a CRC counter ends up at 1.
- R10: The CRC counter of lane i is read at address i/8, in bits [4*(i%8)+3 : 4*(i%8)].
- R11: Reading has no side effects. Addresses above the alignment word read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_err_evt | input | NUM_LANES | Per-lane CRC error pulse |
| sh_err_evt | input | NUM_LANES | Per-lane sync header error pulse |
| rx_align_lost_evt | input | 1 | Receive lane-to-lane alignment lost |
| tx_align_lost_evt | input | 1 | Transmit FIFO overflow/underflow alignment loss |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_data | input | DATA_W | Clear register write data |
| rd_addr | input | ADDR_W | Status word address |
| rd_data | output | DATA_W | Selected status word |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Saturation.** The bench drives a lane with more than fifteen CRC events. A counter that wraps reads back a small value instead of 0xF.
- **Event in the same cycle as a clear.** The bench places an event and a matching clear in one cycle. A design in which the clear wins shows 0 where 1 or a set flag is expected.
- **Clear bits kept apart.** Clears of one kind are issued while other status is loaded. Swapped or shared clear bits wipe the wrong word.
- **Lane placement and reads.** Lanes 9 and 23 and alternating lane patterns catch a nibble or word placed in the wrong spot. Repeated reads, and reads of unmapped addresses, catch a design that clears on read or returns stale data.

// File: rtl/lane_err_pkg.sv
`timescale 1ns/1ps
package lane_err_pkg;
    localparam int NIB_W = 4;

    typedef struct packed {
        logic crc;
        logic sh;
        logic rxloa;
        logic txloa;
    } clr_sel_t;
endpackage

// File: rtl/lane_crc_counter.sv
`timescale 1ns/1ps
module lane_crc_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end
        if (evt_i) begin
            if (clr_i) begin
                st_d.cnt = CNT_W'(1);
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !clr_i && st_q.cnt != CNT_MAX) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == CNT_MAX && !clr_i) |=> (st_q.cnt == CNT_MAX));

    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !evt_i) |=> (st_q.cnt == '0));

    // R9
    clr_evt_win_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && evt_i) |=> (st_q.cnt == CNT_W'(1)));

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !evt_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/lane_sticky_bank.sv
`timescale 1ns/1ps
module lane_sticky_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] evt_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o
);
    typedef struct packed {
        logic [WIDTH-1:0] flags;
    } sticky_state_t;

    sticky_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < WIDTH; b++) begin
            if (clr_i[b]) begin
                st_d.flags[b] = 1'b0;
            end
            if (evt_i[b]) begin
                st_d.flags[b] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flags;

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|(st_q.flags & ~clr_i)) |=> ((st_q.flags & $past(st_q.flags & ~clr_i)) == $past(st_q.flags & ~clr_i)));

    // R9
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((st_q.flags & $past(evt_i)) == $past(evt_i)));

    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~evt_i)) |=> ((st_q.flags & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/lane_status_readmux.sv
`timescale 1ns/1ps
module lane_status_readmux #(
    parameter int NUM_LANES = 24,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int NIB_W     = 4
) (
    input  logic [NUM_LANES*NIB_W-1:0] cnt_flat_i,
    input  logic [NUM_LANES-1:0]       sh_flags_i,
    input  logic                       rxloa_i,
    input  logic                       txloa_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [DATA_W-1:0]          rd_data_o
);
    localparam int LANES_PER_WORD = DATA_W / NIB_W;
    localparam int CRC_WORDS      = (NUM_LANES + LANES_PER_WORD - 1) / LANES_PER_WORD;
    localparam int SH_WORDS       = (NUM_LANES + DATA_W - 1) / DATA_W;
    localparam int SH_BASE        = CRC_WORDS;
    localparam int ALIGN_ADDR     = CRC_WORDS + SH_WORDS;

    logic [CRC_WORDS*DATA_W-1:0] crc_pad;
    logic [SH_WORDS*DATA_W-1:0]  sh_pad;
    int                          addr_n;

    always_comb begin
        crc_pad = '0;
        crc_pad[NUM_LANES*NIB_W-1:0] = cnt_flat_i;
        sh_pad = '0;
        sh_pad[NUM_LANES-1:0] = sh_flags_i;
        addr_n = int'(rd_addr_i);
        rd_data_o = '0;
        if (addr_n < CRC_WORDS) begin
            rd_data_o = crc_pad[addr_n*DATA_W +: DATA_W];
        end else if (addr_n < ALIGN_ADDR) begin
            rd_data_o = sh_pad[(addr_n-SH_BASE)*DATA_W +: DATA_W];
        end else if (addr_n == ALIGN_ADDR) begin
            rd_data_o[0] = rxloa_i;
            rd_data_o[1] = txloa_i;
        end
    end
endmodule

// File: rtl/lane_err_status.sv
`timescale 1ns/1ps
module lane_err_status
    import lane_err_pkg::*;
#(
    parameter int NUM_LANES     = 24,
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 4,
    parameter int CLR_CRC_BIT   = 6,
    parameter int CLR_SH_BIT    = 7,
    parameter int CLR_RXLOA_BIT = 8,
    parameter int CLR_TXLOA_BIT = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LANES-1:0] crc_err_evt,
    input  logic [NUM_LANES-1:0] sh_err_evt,
    input  logic                 rx_align_lost_evt,
    input  logic                 tx_align_lost_evt,
    input  logic                 clr_we,
    input  logic [DATA_W-1:0]    clr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int CNT_BITS = NUM_LANES * NIB_W;

    clr_sel_t              clr_sel;
    logic [CNT_BITS-1:0]   cnt_flat;
    logic [NUM_LANES-1:0]  sh_flags;
    logic [1:0]            loa_flags;

    always_comb begin
        clr_sel.crc   = clr_we & clr_data[CLR_CRC_BIT];
        clr_sel.sh    = clr_we & clr_data[CLR_SH_BIT];
        clr_sel.rxloa = clr_we & clr_data[CLR_RXLOA_BIT];
        clr_sel.txloa = clr_we & clr_data[CLR_TXLOA_BIT];
    end

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_cnt
            lane_crc_counter #(
                .CNT_W (NIB_W)
            ) i_cnt (
                .clk   (clk),
                .rst   (rst),
                .evt_i (crc_err_evt[g]),
                .clr_i (clr_sel.crc),
                .cnt_o (cnt_flat[g*NIB_W +: NIB_W])
            );
        end
    endgenerate

    lane_sticky_bank #(
        .WIDTH (NUM_LANES)
    ) i_sh_bank (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (sh_err_evt),
        .clr_i  ({NUM_LANES{clr_sel.sh}}),
        .flag_o (sh_flags)
    );

    lane_sticky_bank #(
        .WIDTH (2)
    ) i_loa_bank (
        .clk    (clk),
        .rst    (rst),
        .evt_i  ({tx_align_lost_evt, rx_align_lost_evt}),
        .clr_i  ({clr_sel.txloa, clr_sel.rxloa}),
        .flag_o (loa_flags)
    );

    lane_status_readmux #(
        .NUM_LANES (NUM_LANES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NIB_W     (NIB_W)
    ) i_rdmux (
        .cnt_flat_i (cnt_flat),
        .sh_flags_i (sh_flags),
        .rxloa_i    (loa_flags[0]),
        .txloa_i    (loa_flags[1]),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data)
    );

    // R7
    rxloa_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (loa_flags[0] && !clr_sel.rxloa) |=> loa_flags[0]);

    // R8
    txloa_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (loa_flags[1] && !clr_sel.txloa) |=> loa_flags[1]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (cnt_flat == '0 && sh_flags == '0 && loa_flags == 2'b00));
endmodule

// File: tb/test_lane_err_status.sv
`timescale 1ns/1ps
module test_lane_err_status;
    localparam int NL = 24;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NWORDS = 5;

    typedef struct packed {
        logic [NL-1:0] crc;
        logic [NL-1:0] sh;
        logic          rx;
        logic          tx;
        logic          we;
        logic [9:0]    clr;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{24'h000001, 24'h000000, 1'b0, 1'b0, 1'b0, 10'h000}, // R2 single lane
        '{24'h800201, 24'h000000, 1'b0, 1'b0, 1'b0, 10'h000}, // R2 R10 lanes 0,9,23
        '{24'h000000, 24'h820008, 1'b1, 1'b0, 1'b0, 10'h000}, // R5 R7
        '{24'h000000, 24'h000000, 1'b0, 1'b1, 1'b0, 10'h000}, // R8
        '{24'h000000, 24'h000020, 1'b0, 1'b0, 1'b1, 10'h080}, // R6 R9 flag
        '{24'h000200, 24'h000000, 1'b0, 1'b0, 1'b1, 10'h040}, // R4 R9 counter
        '{24'h000000, 24'h000000, 1'b0, 1'b0, 1'b1, 10'h03F}, // R4 unrelated bits
        '{24'h000000, 24'h000000, 1'b0, 1'b0, 1'b1, 10'h100}, // R7 clear
        '{24'h000000, 24'h000000, 1'b0, 1'b1, 1'b1, 10'h200}, // R8 R9
        '{24'hFFFFFF, 24'h000000, 1'b0, 1'b0, 1'b0, 10'h000}, // R2 all lanes
        '{24'hAAAAAA, 24'h555555, 1'b0, 1'b0, 1'b0, 10'h000}, // R10 R5 patterns
        '{24'h000000, 24'h000000, 1'b0, 1'b0, 1'b1, 10'h3C0}  // R4 R6 R7 R8 all clear
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] crc_err_evt;
    logic [NL-1:0] sh_err_evt;
    logic          rx_align_lost_evt;
    logic          tx_align_lost_evt;
    logic          clr_we;
    logic [DW-1:0] clr_data;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int            m_cnt [NL];
    logic [NL-1:0] m_sh;
    logic          m_rx, m_tx;

    always #2.5 clk = ~clk;

    lane_err_status #(.NUM_LANES(NL), .DATA_W(DW), .ADDR_W(AW)) i_lane_err_status (
        .clk(clk), .rst(rst), .crc_err_evt(crc_err_evt), .sh_err_evt(sh_err_evt),
        .rx_align_lost_evt(rx_align_lost_evt), .tx_align_lost_evt(tx_align_lost_evt),
        .clr_we(clr_we), .clr_data(clr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] model_word(input int a);
        logic [DW-1:0] w;
        w = '0;
        if (a < 3) begin
            for (int k = 0; k < 8; k++) w[4*k +: 4] = 4'(m_cnt[a*8+k]);
        end else if (a == 3) begin
            w[NL-1:0] = m_sh;
        end else if (a == 4) begin
            w[0] = m_rx;
            w[1] = m_tx;
        end
        return w;
    endfunction

    task automatic model_reset();
        for (int l = 0; l < NL; l++) m_cnt[l] = 0;
        m_sh = '0; m_rx = 1'b0; m_tx = 1'b0;
    endtask

    task automatic model_apply(input vec_t v);
        for (int l = 0; l < NL; l++) begin
            if (v.we && v.clr[6]) m_cnt[l] = 0;
            if (v.crc[l]) m_cnt[l] = (m_cnt[l] >= 15) ? 15 : m_cnt[l] + 1;
        end
        if (v.we && v.clr[7]) m_sh = '0;
        m_sh = m_sh | v.sh;
        if (v.we && v.clr[8]) m_rx = 1'b0;
        if (v.rx) m_rx = 1'b1;
        if (v.we && v.clr[9]) m_tx = 1'b0;
        if (v.tx) m_tx = 1'b1;
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        crc_err_evt = v.crc; sh_err_evt = v.sh;
        rx_align_lost_evt = v.rx; tx_align_lost_evt = v.tx;
        clr_we = v.we; clr_data = {22'd0, v.clr};
        @(negedge clk);
        crc_err_evt = '0; sh_err_evt = '0;
        rx_align_lost_evt = 1'b0; tx_align_lost_evt = 1'b0;
        clr_we = 1'b0; clr_data = '0;
        model_apply(v);
    endtask

    task automatic check_addr(input int a, input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: actual %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < NWORDS; a++) check_addr(a, model_word(a), req);
    endtask

    initial begin
        vec_t v;
        rst = 1'b1;
        crc_err_evt = '0; sh_err_evt = '0;
        rx_align_lost_evt = 1'b0; tx_align_lost_evt = 1'b0;
        clr_we = 1'b0; clr_data = '0; rd_addr = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset state");

        // Table walk: R2 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            check_all("R2/R4/R5/R6/R7/R8/R9/R10 vector");
        end

        // R2: back-to-back events on lane 2
        v = '0; v.crc[2] = 1'b1;
        @(negedge clk);
        crc_err_evt = v.crc;
        repeat (3) @(negedge clk);
        crc_err_evt = '0;
        for (int k = 0; k < 3; k++) model_apply(v);
        check_addr(0, model_word(0), "R2 consecutive");

        // R3: saturation on lane 12
        v = '0; v.crc[12] = 1'b1;
        for (int k = 0; k < 20; k++) drive(v);
        check_addr(1, 32'h000F_0000, "R3 saturate");
        drive(v);
        check_addr(1, 32'h000F_0000, "R3 hold at max");

        // R11: repeated reads, unmapped addresses
        v = '0; v.sh[21] = 1'b1; v.rx = 1'b1;
        drive(v);
        for (int k = 0; k < 3; k++) check_addr(3, model_word(3), "R11 read no side effect");
        check_addr(4, model_word(4), "R11 align after reads");
        check_addr(1, model_word(1), "R11 counters after reads");
        for (int a = NWORDS; a < 16; a++) check_addr(a, '0, "R11 unmapped");

        // R1: reset while loaded
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1 mid-run reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule